// File: doc/BRIEF.md
# Floating-Point Control and Status Unit

This unit sits next to an in-order issue stage. It holds the floating-point control state (rounding mode, exception masks, flush-to-zero) in one 8-bit register. Sticky exception flags live in a separate 5-bit register. Every floating-point operation that leaves issue takes a copy of the control register on `op_ctrl`. The execution units use that copy and never consult the live register. A control write changes only operations that issue after it.

Issue uses a valid/ready handshake. Ready drops while a control write is being presented, so an operation presented in that cycle waits one cycle and then leaves with the new value. Ready also drops when the in-flight counter is full. Completions return flag bits, which are ORed into the sticky flags. A status read also uses valid/ready and is held off until every older operation has completed, so the value it returns is final. A control read is a plain combinational read of the register. Software can only clear the flags with a strobe; no write path reaches them.

Top module: `fp_ctrl_unit`

## Requirements
- R1: After synchronous reset the control register reads 8'h7C, the flags read 0, the in-flight count is 0, `op_ready` is 1 and `st_rd_ready` is 1. The reset value 8'h7C means round-to-nearest, all five exceptions masked and flush-to-zero off.
- R2: A whole write (`ctrl_wr_mode`=0) replaces all 8 control bits at the clock edge. The control layout is: bits [1:0] rounding mode (0 nearest, 1 toward zero, 2 up, 3 down), bits [6:2] exception masks, bit 7 flush-to-zero.
- R3: A field write (`ctrl_wr_mode`=1) updates only the nibble chosen by `ctrl_wr_sel`: 0 selects bits [3:0], 1 selects bits [7:4]. The new value is taken from the same bit positions of `ctrl_wr_data`. The other nibble keeps its value.
- R4: An issued operation (`op_valid` and `op_ready` both high) sees `op_ctrl` equal to the control register value of that cycle.
- R5: While `ctrl_wr_en` is high, `op_ready` is 0. The operation is held and issues in the next cycle with the newly written value.
- R6: Control writes never change the status flags.
- R7: An accepted completion ORs `cmp_flags` into the sticky flags at the clock edge. Flags that are set stay set until cleared.
- R8: `st_clr` zeroes the flags at the clock edge. Flags from a completion accepted in the same cycle are still merged in.
- R9: `st_rd_ready` is high only when the in-flight count is 0. While it is low, the request is held. When it is high, `st_rd_data` holds the final flags.
- R10: The in-flight count goes up by one on each issue and down by one on each accepted completion. At 15 (the maximum of the 4-bit counter), `op_ready` is 0.
- R11: A completion that arrives while the in-flight count is 0 is ignored. The count stays 0 and the flags do not change.
- R12: `ctrl_rd_data` shows the control register in the same cycle, with no wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_wr_en | input | 1 | Control write strobe |
| ctrl_wr_mode | input | 1 | 0 whole register, 1 single nibble |
| ctrl_wr_sel | input | 1 | Nibble select for a field write |
| ctrl_wr_data | input | 8 | Write data |
| ctrl_rd_data | output | 8 | Live control register |
| op_valid | input | 1 | FP operation wants to issue |
| op_ready | output | 1 | Issue allowed |
| op_ctrl | output | 8 | Control copy tagged onto the issuing operation |
| cmp_valid | input | 1 | An operation completes |
| cmp_flags | input | 5 | Exception flags from the completion |
| st_clr | input | 1 | Clear sticky flags |
| st_rd_valid | input | 1 | Status read request |
| st_rd_ready | output | 1 | Status read granted |
| st_rd_data | output | 5 | Sticky flags |
| inflight | output | 4 | Operations issued but not yet completed |

## Verification
`op_ready`, `op_ctrl`, `ctrl_rd_data` and `st_rd_ready` are combinational from the current inputs and registers. They are due in the same cycle as the stimulus and are sampled 1 ns after the inputs change, before the next rising edge. Register updates (control value, flags, in-flight count) are due one edge later. The bench updates its model at that edge and compares in the following cycle's sample window. This is also how the R5 hold is seen: ready is low in the write cycle, and the next cycle's tag equals the new value.

// File: rtl/fpcu_pkg.sv
package fpcu_pkg;
    localparam int CTRL_W = 8;
    localparam int FLAG_W = 5;
    localparam int NIB_W  = 4;

    typedef enum logic [1:0] {
        RND_NEAR = 2'd0,
        RND_ZERO = 2'd1,
        RND_UP   = 2'd2,
        RND_DOWN = 2'd3
    } rnd_e;

    // bit 7 ftz, bits 6:2 masks, bits 1:0 rounding
    typedef struct packed {
        logic       ftz;
        logic [4:0] xmask;
        rnd_e       rnd;
    } ctrl_t;

    typedef enum logic {
        WR_WHOLE  = 1'b0,
        WR_NIBBLE = 1'b1
    } wr_mode_e;

    localparam ctrl_t CTRL_RST = '{ftz: 1'b0, xmask: 5'h1F, rnd: RND_NEAR};

    function automatic logic [CTRL_W-1:0] merge_ctrl(
        input logic [CTRL_W-1:0] old_v,
        input logic [CTRL_W-1:0] new_v,
        input wr_mode_e          mode,
        input logic              sel
    );
        logic [CTRL_W-1:0] r;
        r = old_v;
        if (mode == WR_WHOLE) begin
            r = new_v;
        end else if (sel) begin
            r[CTRL_W-1:NIB_W] = new_v[CTRL_W-1:NIB_W];
        end else begin
            r[NIB_W-1:0] = new_v[NIB_W-1:0];
        end
        return r;
    endfunction
endpackage

// File: rtl/fpcu_ctrl_reg.sv
module fpcu_ctrl_reg
    import fpcu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  wr_mode_e          wr_mode,
    input  logic              wr_sel,
    input  logic [CTRL_W-1:0] wr_data,
    output ctrl_t             ctrl_o
);
    logic [CTRL_W-1:0] ctrl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= CTRL_RST;
        end else if (wr_en) begin
            ctrl_q <= merge_ctrl(ctrl_q, wr_data, wr_mode, wr_sel);
        end
    end

    assign ctrl_o = ctrl_t'(ctrl_q);

    // R2: whole write lands completely
    p_whole_write_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_mode == WR_WHOLE) |=> ctrl_q == $past(wr_data));
    // R3: field write leaves the other nibble alone
    p_nibble_keep_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_mode == WR_NIBBLE && !wr_sel) |=>
            ctrl_q[CTRL_W-1:NIB_W] == $past(ctrl_q[CTRL_W-1:NIB_W]));
    p_nibble_keep_hi_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_mode == WR_NIBBLE && wr_sel) |=>
            ctrl_q[NIB_W-1:0] == $past(ctrl_q[NIB_W-1:0]));
    // R12: without a write the register holds
    p_hold_r12: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(ctrl_q));
endmodule

// File: rtl/fpcu_track.sv
module fpcu_track #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             issue_i,
    input  logic             done_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             full_o,
    output logic             empty_o,
    output logic             done_ok_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;

    assign full_o    = (cnt_q == CNT_MAX);
    assign empty_o   = (cnt_q == '0);
    assign done_ok_o = done_i && !empty_o;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            case ({issue_i, done_ok_o})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign cnt_o = cnt_q;

    // R10: no issue accepted at the limit
    p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == CNT_MAX) |=> cnt_q != '0);
    // R11: an empty counter cannot be decremented
    p_no_underflow_r11: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == '0 && !issue_i) |=> cnt_q == '0);
endmodule

// File: rtl/fpcu_status.sv
module fpcu_status
    import fpcu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              merge_i,
    input  logic [FLAG_W-1:0] flags_i,
    input  logic              clr_i,
    output logic [FLAG_W-1:0] flags_o
);
    logic [FLAG_W-1:0] flags_q;
    logic [FLAG_W-1:0] base;

    always_comb begin
        base = clr_i ? '0 : flags_q;
        if (merge_i) begin
            base = base | flags_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= base;
    end

    assign flags_o = flags_q;

    // R7: set flags stay set unless cleared
    p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        !clr_i |=> (flags_q & $past(flags_q)) == $past(flags_q));
    // R8: clear without merge empties the register
    p_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !merge_i) |=> flags_q == '0);
    // R6/R11: nothing changes without clear or merge
    p_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        (!clr_i && !merge_i) |=> $stable(flags_q));
endmodule

// File: rtl/fp_ctrl_unit.sv
module fp_ctrl_unit
    import fpcu_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_wr_en,
    input  logic              ctrl_wr_mode,
    input  logic              ctrl_wr_sel,
    input  logic [CTRL_W-1:0] ctrl_wr_data,
    output logic [CTRL_W-1:0] ctrl_rd_data,
    input  logic              op_valid,
    output logic              op_ready,
    output logic [CTRL_W-1:0] op_ctrl,
    input  logic              cmp_valid,
    input  logic [FLAG_W-1:0] cmp_flags,
    input  logic              st_clr,
    input  logic              st_rd_valid,
    output logic              st_rd_ready,
    output logic [FLAG_W-1:0] st_rd_data,
    output logic [CNT_W-1:0]  inflight
);
    ctrl_t ctrl_cur;
    logic  cnt_full, cnt_empty, done_ok, issue;

    fpcu_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (ctrl_wr_en),
        .wr_mode (wr_mode_e'(ctrl_wr_mode)),
        .wr_sel  (ctrl_wr_sel),
        .wr_data (ctrl_wr_data),
        .ctrl_o  (ctrl_cur)
    );

    // issue barrier: a write in flight this cycle holds younger ops
    assign op_ready = !ctrl_wr_en && !cnt_full;
    assign issue    = op_valid && op_ready;
    assign op_ctrl  = ctrl_cur;
    assign ctrl_rd_data = ctrl_cur;

    fpcu_track #(.CNT_W(CNT_W)) u_track (
        .clk       (clk),
        .rst       (rst),
        .issue_i   (issue),
        .done_i    (cmp_valid),
        .cnt_o     (inflight),
        .full_o    (cnt_full),
        .empty_o   (cnt_empty),
        .done_ok_o (done_ok)
    );

    fpcu_status u_stat (
        .clk     (clk),
        .rst     (rst),
        .merge_i (done_ok),
        .flags_i (cmp_flags),
        .clr_i   (st_clr),
        .flags_o (st_rd_data)
    );

    assign st_rd_ready = cnt_empty;

    // R5: no issue while a control write is presented
    p_barrier_r5: assert property (@(posedge clk) disable iff (rst)
        ctrl_wr_en |-> !op_ready);
    // R9: granted status read implies nothing in flight
    p_drain_r9: assert property (@(posedge clk) disable iff (rst)
        (st_rd_valid && st_rd_ready) |-> inflight == '0);
    // R4: a tag issued right after a write carries the written value
    p_tag_r4: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr_en && ctrl_wr_mode == 1'b0) |=> op_ctrl == $past(ctrl_wr_data));
endmodule

// File: tb/tb_fp_ctrl_unit.sv
`timescale 1ns/1ps
module tb_fp_ctrl_unit;
    logic       clk = 1'b0;
    logic       rst;
    logic       ctrl_wr_en, ctrl_wr_mode, ctrl_wr_sel;
    logic [7:0] ctrl_wr_data, ctrl_rd_data, op_ctrl;
    logic       op_valid, op_ready, cmp_valid, st_clr, st_rd_valid, st_rd_ready;
    logic [4:0] cmp_flags, st_rd_data;
    logic [3:0] inflight;

    int checks = 0;
    int errors = 0;
    logic [7:0] m_ctrl;
    logic [4:0] m_flags;
    int         m_cnt;
    string      ctag, ftag;

    always #2.5 clk = ~clk;

    fp_ctrl_unit dut (.*);

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_merge(input logic [7:0] o, input logic [7:0] d,
                                             input logic m, input logic s);
        if (!m) return d;
        if (s)  return {d[7:4], o[3:0]};
        return {o[7:4], d[3:0]};
    endfunction

    // drive at negedge, sample 1 ns later, update model at posedge
    task automatic cyc(input logic we, input logic wm, input logic ws, input logic [7:0] wd,
                       input logic ov, input logic cv, input logic [4:0] cf,
                       input logic clr, input logic srv);
        logic ready_e, iss, ok;
        @(negedge clk);
        ctrl_wr_en = we; ctrl_wr_mode = wm; ctrl_wr_sel = ws; ctrl_wr_data = wd;
        op_valid = ov; cmp_valid = cv; cmp_flags = cf; st_clr = clr; st_rd_valid = srv;
        #1;
        ready_e = !we && (m_cnt != 15);
        chk(ctag, ctrl_rd_data, m_ctrl);
        if (we && ov) chk("R5", op_ready, 0);
        else          chk("R10", op_ready, ready_e);
        if (ov && op_ready) chk("R4", op_ctrl, m_ctrl);
        chk("R9", st_rd_ready, m_cnt == 0);
        if (st_rd_ready) chk(ftag, st_rd_data, m_flags);
        chk("R10", inflight, m_cnt);
        iss = ov && ready_e;
        ok  = cv && m_cnt != 0;
        @(posedge clk);
        ctag = !we ? "R12" : (wm ? "R3" : "R2");
        ftag = clr ? "R8" : (cv && !ok) ? "R11" : we ? "R6" : "R7";
        if (we) m_ctrl = exp_merge(m_ctrl, wd, wm, ws);
        m_flags = (clr ? 5'd0 : m_flags) | (ok ? cf : 5'd0);
        m_cnt = m_cnt + (iss ? 1 : 0) - (ok ? 1 : 0);
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1'b1;
        ctrl_wr_en = 0; ctrl_wr_mode = 0; ctrl_wr_sel = 0; ctrl_wr_data = 0;
        op_valid = 0; cmp_valid = 0; cmp_flags = 0; st_clr = 0; st_rd_valid = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0; #1;
        chk("R1", ctrl_rd_data, 8'h7C);
        chk("R1", st_rd_data, 0);
        chk("R1", inflight, 0);
        chk("R1", op_ready, 1);
        chk("R1", st_rd_ready, 1);
        m_ctrl = 8'h7C; m_flags = 0; m_cnt = 0; ctag = "R12"; ftag = "R7";

        // R11: completion with nothing in flight
        cyc(0,0,0,0, 0,1,5'h1F, 0,1);
        // R2 then R5: write with op waiting, op issues next cycle with new tag
        cyc(1,0,0,8'hA3, 1,0,0, 0,0);
        cyc(0,0,0,0, 1,0,0, 0,1);
        // R3: both nibbles
        cyc(1,1,0,8'hF5, 0,0,0, 0,0);
        cyc(1,1,1,8'h2F, 0,0,0, 0,0);
        // R10: fill to the limit
        for (int i = 0; i < 17; i++) cyc(0,0,0,0, 1,0,0, 0,1);
        // R9/R7: drain with flags while reading status
        for (int i = 0; i < 16; i++) cyc(0,0,0,0, 0,1,5'(1 << (i % 5)), 0,1);
        // R8: clear with a merge in the same cycle
        cyc(0,0,0,0, 1,0,0, 0,0);
        cyc(0,0,0,0, 0,1,5'h04, 1,0);
        cyc(0,0,0,0, 0,0,0, 0,1);
        // random mix
        for (int i = 0; i < 3000; i++) begin
            cyc(($urandom % 8) == 0, $urandom % 2, $urandom % 2, 8'($urandom),
                ($urandom % 3) != 0, ($urandom % 2) == 0, 5'($urandom),
                ($urandom % 20) == 0, $urandom % 2);
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule